// File: doc/BRIEF.md
# Vector Lane Bit Modify Unit

This execution unit sits in a 128-bit vector pipeline. It takes one 32-bit instruction word and two vector operands. It then clears, sets or inverts exactly one bit in every element of the first operand. The vector is split into elements of 8, 16, 32 or 64 bits. The instruction chooses the element size, the operation, and where the bit number comes from. The bit number can come from the same element of the second operand, in which case only its low bits count. It can also come from an immediate field that is shared by all elements.

The instruction word is decoded against a fixed set of opcode patterns. A strobed word that matches none of them raises an illegal flag and produces no result. The result, the destination register number and both flags are registered, so they appear one clock after the strobe. The register file reads and writes the operands outside this block.

Top module: `bitmod_unit`

## Requirements
- R1: The element width is 8, 16, 32 or 64 bits, giving 16, 8, 4 or 2 elements. No result bit of one element depends on any other element, and nothing carries between elements.
- R2: The clear operation returns each element AND NOT (1 << n), where n is that element's bit number.
- R3: The set operation returns each element OR (1 << n).
- R4: The invert operation returns each element XOR (1 << n).
- R5: In the register-index forms, n is the low 3, 4, 5 or 6 bits of the matching element of srcB, which is srcB modulo the element width. The higher bits of that element have no effect.
- R6: In the immediate forms, one immediate n is used for every element, and srcB has no effect.
- R7: The register-index forms are recognised by instruction bits [31:20] and [19:17]:
  - [31:20] = 0111_0001_0000 with [19:17] = 110 selects clear.
  - [31:20] = 0111_0001_0000 with [19:17] = 111 selects set.
  - [31:20] = 0111_0001_0001 with [19:17] = 000 selects invert.
  - Bits [16:15] give the element width: 00 for 8, 01 for 16, 10 for 32 and 11 for 64 bits.
- R8: The immediate forms are recognised by instruction bits [31:20] = 0111_0011_0001. Bits [19:18] select the operation: 00 clear, 01 set, 10 invert. The element width and immediate then come from the low field:
  - [17:13] = 00001 gives 8-bit elements, with the immediate in [12:10].
  - [17:14] = 0001 gives 16-bit elements, with the immediate in [13:10].
  - [17:15] = 001 gives 32-bit elements, with the immediate in [14:10].
  - [17:16] = 01 gives 64-bit elements, with the immediate in [15:10].
- R9: For a legal word, outRd carries instruction bits [4:0].
- R10: A strobed word that matches no pattern in R7 or R8 raises outIllegal for one cycle and keeps outValid low. This includes [19:18] = 11 and an immediate low field that matches none of the four width codes.
- R11: outValid or outIllegal rises exactly one clock after a strobe. Without a strobe, both stay low.
- R12: A synchronous active-high reset clears outValid and outIllegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | The instruction and operands are valid this cycle |
| insn | input | 32 | Instruction word |
| srcA | input | 128 | Operand whose elements are modified |
| srcB | input | 128 | Per-element bit numbers for the register-index forms |
| outResult | output | 128 | Modified vector |
| outRd | output | 5 | Destination register number |
| outValid | output | 1 | outResult and outRd are valid |
| outIllegal | output | 1 | The previous strobed word was not recognised |

## Verification
The bench targets the highest bit number of each width, where a mask that carries into the next element would change two elements instead of one. It sets the upper bits of every srcB element, where a missing modulo would move or drop the bit. In the immediate forms it drives srcB with noise, which exposes a mux that picks the wrong bit-number source. It sends near-miss encodings, such as operation code 11, a zero immediate low field and a wrong sub-opcode. A loose decoder would produce a result for these where an illegal flag is due. Random legal and random words, idle gaps and a strobe held during reset cover the rest of the timing.

// File: rtl/bitmod_pkg.sv
`timescale 1ns/1ps
package bitmod_pkg;
  localparam int VLEN   = 128;
  localparam int INSN_W = 32;
  localparam int NWIDTH = 4;   // element widths 8 << k, k = 0..3
  localparam int IMM_W  = 6;

  // Strobes from the decoder to the lane datapath
  typedef struct packed {
    logic             legal;
    logic             opClr;
    logic             opSet;
    logic             opInv;
    logic [1:0]       widthSel;
    logic             useImm;
    logic [IMM_W-1:0] immIdx;
  } bitmod_ctrl_t;
endpackage

// File: rtl/bitmod_decode.sv
`timescale 1ns/1ps
module bitmod_decode
  import bitmod_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output bitmod_ctrl_t      ctrl
);
  localparam logic [11:0] REG_GRP0 = 12'b0111_0001_0000;
  localparam logic [11:0] REG_GRP1 = 12'b0111_0001_0001;
  localparam logic [11:0] IMM_GRP  = 12'b0111_0011_0001;

  logic [11:0] major;
  logic [2:0]  regSub;
  logic [1:0]  immOp;
  logic [7:0]  immLow;
  logic        unusedFields;

  assign major  = insn[31:20];
  assign regSub = insn[19:17];
  assign immOp  = insn[19:18];
  assign immLow = insn[17:10];
  assign unusedFields = ^insn[9:5];

  always_comb begin
    ctrl = '0;
    if (major == REG_GRP0 && regSub[2:1] == 2'b11) begin
      ctrl.legal    = 1'b1;
      ctrl.opClr    = ~regSub[0];
      ctrl.opSet    = regSub[0];
      ctrl.widthSel = insn[16:15];
    end else if (major == REG_GRP1 && regSub == 3'b000) begin
      ctrl.legal    = 1'b1;
      ctrl.opInv    = 1'b1;
      ctrl.widthSel = insn[16:15];
    end else if (major == IMM_GRP && immOp != 2'b11) begin
      ctrl.useImm = 1'b1;
      ctrl.opClr  = (immOp == 2'b00);
      ctrl.opSet  = (immOp == 2'b01);
      ctrl.opInv  = (immOp == 2'b10);
      casez (immLow)
        8'b0000_1???: begin ctrl.legal = 1'b1; ctrl.widthSel = 2'd0; ctrl.immIdx = {3'b000, immLow[2:0]}; end
        8'b0001_????: begin ctrl.legal = 1'b1; ctrl.widthSel = 2'd1; ctrl.immIdx = {2'b00, immLow[3:0]}; end
        8'b001?_????: begin ctrl.legal = 1'b1; ctrl.widthSel = 2'd2; ctrl.immIdx = {1'b0, immLow[4:0]}; end
        8'b01??_????: begin ctrl.legal = 1'b1; ctrl.widthSel = 2'd3; ctrl.immIdx = immLow[5:0]; end
        default:      ctrl = '0;
      endcase
    end
  end
endmodule

// File: rtl/bitmod_lane.sv
`timescale 1ns/1ps
module bitmod_lane #(
  parameter int EW = 8,
  localparam int IW = $clog2(EW)
) (
  input  logic [EW-1:0] laneIn,
  input  logic [IW-1:0] bitIdx,
  input  logic          opClr,
  input  logic          opSet,
  input  logic          opInv,
  output logic [EW-1:0] laneOut
);
  logic [EW-1:0] onehot;
  assign onehot = {{(EW-1){1'b0}}, 1'b1} << bitIdx;

  always_comb begin
    laneOut = laneIn;
    if (opClr)      laneOut = laneIn & ~onehot;
    else if (opSet) laneOut = laneIn | onehot;
    else if (opInv) laneOut = laneIn ^ onehot;
  end
endmodule

// File: rtl/bitmod_datapath.sv
`timescale 1ns/1ps
module bitmod_datapath
  import bitmod_pkg::*;
(
  input  bitmod_ctrl_t    ctrl,
  input  logic [VLEN-1:0] vecA,
  input  logic [VLEN-1:0] vecB,
  output logic [VLEN-1:0] vecOut
);
  logic [VLEN-1:0] perWidth [NWIDTH];
  logic            unusedB;

  assign unusedB = ^vecB;

  for (genvar g = 0; g < NWIDTH; g++) begin : g_width
    localparam int EW = 8 << g;
    localparam int NL = VLEN / EW;
    localparam int IW = 3 + g;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [IW-1:0] idx;
      assign idx = ctrl.useImm ? ctrl.immIdx[IW-1:0] : vecB[l*EW +: IW];
      bitmod_lane #(.EW(EW)) u_lane (
        .laneIn (vecA[l*EW +: EW]),
        .bitIdx (idx),
        .opClr  (ctrl.opClr),
        .opSet  (ctrl.opSet),
        .opInv  (ctrl.opInv),
        .laneOut(perWidth[g][l*EW +: EW])
      );
    end
  end

  assign vecOut = perWidth[ctrl.widthSel];
endmodule

// File: rtl/bitmod_unit.sv
`timescale 1ns/1ps
module bitmod_unit
  import bitmod_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [INSN_W-1:0] insn,
  input  logic [VLEN-1:0]   srcA,
  input  logic [VLEN-1:0]   srcB,
  output logic [VLEN-1:0]   outResult,
  output logic [4:0]        outRd,
  output logic              outValid,
  output logic              outIllegal
);
  bitmod_ctrl_t    ctrlS;
  logic [VLEN-1:0] resD;

  bitmod_decode u_dec (.insn(insn), .ctrl(ctrlS));

  bitmod_datapath u_dp (
    .ctrl  (ctrlS),
    .vecA  (srcA),
    .vecB  (srcB),
    .vecOut(resD)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid   <= 1'b0;
      outIllegal <= 1'b0;
    end else begin
      outValid   <= inValid & ctrlS.legal;
      outIllegal <= inValid & ~ctrlS.legal;
    end
  end

  always_ff @(posedge clk) begin
    if (inValid && ctrlS.legal) begin
      outResult <= resD;
      outRd     <= insn[4:0];
    end
  end
endmodule

// File: rtl/bitmod_unit_chk.sv
`timescale 1ns/1ps
module bitmod_unit_chk
  import bitmod_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [INSN_W-1:0] insn,
  input logic [VLEN-1:0]   srcA,
  input logic [VLEN-1:0]   outResult,
  input logic [4:0]        outRd,
  input logic              outValid,
  input logic              outIllegal,
  input bitmod_ctrl_t      ctrlS
);
  // R10
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(outValid && outIllegal));

  // R11
  strobe_answered_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inValid)) |-> (outValid || outIllegal));

  // R11
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid || outIllegal) |-> $past(inValid));

  // R9
  dest_echo_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outRd == $past(insn[4:0])));

  // R3
  set_superset_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(ctrlS.opSet)) |-> ((outResult & $past(srcA)) == $past(srcA)));

  // R2
  clr_subset_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(ctrlS.opClr)) |-> ((outResult | $past(srcA)) == $past(srcA)));

  // R4
  inv_one_per_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(ctrlS.opInv)) |->
      ($countones(outResult ^ $past(srcA)) == (32'd16 >> $past(ctrlS.widthSel))));
endmodule

bind bitmod_unit bitmod_unit_chk u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .insn(insn), .srcA(srcA),
  .outResult(outResult), .outRd(outRd), .outValid(outValid),
  .outIllegal(outIllegal), .ctrlS(ctrlS)
);

// File: tb/bitmod_unit_bench.sv
`timescale 1ns/1ps
module bitmod_unit_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [31:0]  insn = '0;
  logic [127:0] srcA = '0;
  logic [127:0] srcB = '0;
  logic [127:0] outResult;
  logic [4:0]   outRd;
  logic         outValid;
  logic         outIllegal;

  bitmod_unit u_bitmod_unit (.*);

  always #5 clk = ~clk;

  int nVec = 0;
  int nBad = 0;
  bit armed = 0;
  bit finished = 0;
  logic         expValid, expIllegal;
  logic [127:0] expRes;
  logic [4:0]   expRd;
  string        expTag;

  // Behavioural decode following R7 and R8; op: 0 clear, 1 set, 2 invert
  function automatic void refDecode(input logic [31:0] w, output bit legal,
      output int op, output int ws, output bit useImm, output int imm);
    legal = 0; op = 0; ws = 0; useImm = 0; imm = 0;
    if (w[31:20] == 12'b0111_0001_0000 && w[19:17] == 3'b110) begin
      legal = 1; op = 0; ws = int'(w[16:15]);
    end else if (w[31:20] == 12'b0111_0001_0000 && w[19:17] == 3'b111) begin
      legal = 1; op = 1; ws = int'(w[16:15]);
    end else if (w[31:20] == 12'b0111_0001_0001 && w[19:17] == 3'b000) begin
      legal = 1; op = 2; ws = int'(w[16:15]);
    end else if (w[31:20] == 12'b0111_0011_0001 && w[19:18] != 2'b11) begin
      useImm = 1; op = int'(w[19:18]);
      if (w[17:13] == 5'b00001)     begin legal = 1; ws = 0; imm = int'(w[12:10]); end
      else if (w[17:14] == 4'b0001) begin legal = 1; ws = 1; imm = int'(w[13:10]); end
      else if (w[17:15] == 3'b001)  begin legal = 1; ws = 2; imm = int'(w[14:10]); end
      else if (w[17:16] == 2'b01)   begin legal = 1; ws = 3; imm = int'(w[15:10]); end
    end
  endfunction

  function automatic logic [127:0] refApply(input int op, input int ws, input bit useImm,
      input int imm, input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r = a;
    int ew = 8 << ws;
    for (int lane = 0; lane < 128 / ew; lane++) begin
      int idx = 0;
      if (useImm) idx = imm;
      else for (int k = 0; k < 3 + ws; k++) idx += int'(b[lane*ew + k]) << k;
      case (op)
        0: r[lane*ew + idx] = 1'b0;
        1: r[lane*ew + idx] = 1'b1;
        default: r[lane*ew + idx] = ~r[lane*ew + idx];
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] regInsn(input int op, input int ws, input logic [4:0] rd);
    logic [31:0] w = '0;
    w[31:20] = (op == 2) ? 12'b0111_0001_0001 : 12'b0111_0001_0000;
    w[19:17] = (op == 0) ? 3'b110 : (op == 1) ? 3'b111 : 3'b000;
    w[16:15] = 2'(ws);
    w[14:5]  = 10'h2A5;
    w[4:0]   = rd;
    return w;
  endfunction

  function automatic logic [31:0] immInsn(input int op, input int ws, input int imm,
      input logic [4:0] rd);
    logic [31:0] w = '0;
    w[31:20] = 12'b0111_0011_0001;
    w[19:18] = 2'(op);
    case (ws)
      0: begin w[17:13] = 5'b00001; w[12:10] = 3'(imm); end
      1: begin w[17:14] = 4'b0001;  w[13:10] = 4'(imm); end
      2: begin w[17:15] = 3'b001;   w[14:10] = 5'(imm); end
      default: begin w[17:16] = 2'b01; w[15:10] = 6'(imm); end
    endcase
    w[9:5] = 5'h13;
    w[4:0] = rd;
    return w;
  endfunction

  task automatic compareNow();
    if (!armed) return;
    nVec++;
    if (outValid !== expValid || outIllegal !== expIllegal ||
        (expValid && (outResult !== expRes || outRd !== expRd))) begin
      nBad++;
      $display("FAIL %s: valid=%b illegal=%b rd=%0d res=%h | expected valid=%b illegal=%b rd=%0d res=%h",
               expTag, outValid, outIllegal, outRd, outResult,
               expValid, expIllegal, expRd, expRes);
    end
  endtask

  // One clock: check the previous vector's outputs, then drive the next one
  task automatic step(input bit r, input bit v, input logic [31:0] w,
      input logic [127:0] a, input logic [127:0] b, input string tag);
    bit legal, useImm;
    int op, ws, imm;
    @(negedge clk);
    compareNow();
    rst = r; inValid = v; insn = w; srcA = a; srcB = b;
    refDecode(w, legal, op, ws, useImm, imm);
    expTag     = tag;
    expValid   = !r && v && legal;
    expIllegal = !r && v && !legal;
    expRes     = refApply(op, ws, useImm, imm, a, b);
    expRd      = w[4:0];
    armed      = 1;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    logic [127:0] ones = '1;
    // R12: strobe held during reset must not produce a result
    step(1, 1, regInsn(1, 0, 5'd3), rnd128(), rnd128(), "R12");
    step(1, 1, 32'h0, rnd128(), rnd128(), "R12");
    step(0, 0, 32'h0, '0, '0, "R12");
    step(0, 0, regInsn(0, 1, 5'd1), '0, '0, "R11");

    // R2 R3 R4 R7 R1: register forms at every width, max index in every lane
    for (int op = 0; op < 3; op++)
      for (int ws = 0; ws < 4; ws++) begin
        step(0, 1, regInsn(op, ws, 5'(op*4 + ws)), (op == 1) ? '0 : ones, ones, "R1");
        step(0, 1, regInsn(op, ws, 5'd7), rnd128(), rnd128(), "R7");
      end

    // R5: upper bits of each srcB element must be ignored
    step(0, 1, regInsn(1, 0, 5'd9), '0, {16{8'hF8}}, "R5");
    step(0, 1, regInsn(2, 1, 5'd9), '0, {8{16'hFFF1}}, "R5");
    step(0, 1, regInsn(0, 2, 5'd9), ones, {4{32'hFFFF_FFE5}}, "R5");
    step(0, 1, regInsn(1, 3, 5'd9), '0, {2{64'hFFFF_FFFF_FFFF_FFC0}}, "R5");

    // R6 R8: immediate forms, every width, boundary immediates, noisy srcB
    for (int op = 0; op < 3; op++)
      for (int ws = 0; ws < 4; ws++) begin
        step(0, 1, immInsn(op, ws, 0, 5'd30), rnd128(), rnd128(), "R6");
        step(0, 1, immInsn(op, ws, (8 << ws) - 1, 5'd17), rnd128(), ones, "R8");
      end

    // R10: near-miss encodings
    step(0, 1, 32'h0, rnd128(), rnd128(), "R10");
    step(0, 1, {12'b0111_0011_0001, 2'b11, 8'b0000_1010, 10'h0}, rnd128(), rnd128(), "R10");
    step(0, 1, {12'b0111_0011_0001, 2'b00, 8'b0000_0111, 10'h0}, rnd128(), rnd128(), "R10");
    step(0, 1, {12'b0111_0011_0001, 2'b01, 8'b1000_0000, 10'h0}, rnd128(), rnd128(), "R10");
    step(0, 1, {12'b0111_0001_0000, 3'b100, 17'h0}, rnd128(), rnd128(), "R10");
    step(0, 1, {12'b0111_0001_0001, 3'b001, 17'h0}, rnd128(), rnd128(), "R10");
    step(0, 1, regInsn(2, 3, 5'd4), rnd128(), rnd128(), "R9");

    // R11: idle gaps after legal and illegal strobes
    step(0, 0, regInsn(1, 2, 5'd2), rnd128(), rnd128(), "R11");
    step(0, 0, 32'hFFFF_FFFF, rnd128(), rnd128(), "R11");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int kind = int'($urandom_range(0, 4));
      int op   = int'($urandom_range(0, 2));
      int ws   = int'($urandom_range(0, 3));
      logic [4:0] rd = 5'($urandom());
      case (kind)
        0, 1: step(0, 1, regInsn(op, ws, rd), rnd128(), rnd128(), "R5");
        2:    step(0, 1, immInsn(op, ws, int'($urandom_range(0, (8 << ws) - 1)), rd),
                   rnd128(), rnd128(), "R6");
        3:    step(0, 1, $urandom(), rnd128(), rnd128(), "R10");
        default: step(0, 0, $urandom(), rnd128(), rnd128(), "R11");
      endcase
    end

    // R12: reset mid-stream drops a pending strobe
    step(0, 1, regInsn(0, 0, 5'd1), rnd128(), rnd128(), "R2");
    step(1, 1, regInsn(0, 0, 5'd1), rnd128(), rnd128(), "R12");
    step(0, 0, 32'h0, '0, '0, "R12");
    @(negedge clk);
    compareNow();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule